// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider with Synchronous Reload

This block is the programmable divider that sits behind a dual-modulus prescaler in a frequency synthesizer. It counts prescaler output events and drives the modulus-select line back to the prescaler. A swallow counter and a main counter together make one feedback division of P·N + A input cycles, where P is the lower prescaler modulus. A separate reference counter divides qualified reference events by R. The block emits one-cycle feedback and reference pulses for a phase/frequency detector. It also holds the selection code for the charge-pump current.

New divide values arrive as parallel words with a write strobe. In immediate mode a word goes straight into the working (data) register. The counters pick it up the next time they wrap. In staged mode every word first lands in a holding (shadow) register. A main-counter word arms a transfer. On the next count of two in the main counter, the R, A and N working registers are loaded together. The current code follows one full main-counter division later. Because of this, no feedback period is ever built from a mix of old and new values, and the new current takes effect together with the first new-value period. A counter-off input freezes the dividers. While it is high, they track their working registers, so they restart at once with fresh values when it falls.

Top module: `swallow_div`

## Requirements
- R1: Each feedback cycle spans N prescaler events. `mod_hi` is high from a reload until the swallow count A has been used up, then low until the next reload. With a prescaler dividing by P+1 while `mod_hi` is high and by P otherwise, successive `fb_pulse` assertions are P·N + A input cycles apart.
- R2: `fb_pulse` is high for exactly one clock, in the cycle after the `psc_tick` that completes the main count.
- R3: `ref_pulse` is high for one clock, in the cycle after every R-th `ref_tick`.
- R4: Writes use the `wr_sel` code 0 for the main word (N in `wr_data[NW-1:0]`, A in `wr_data[NW+AW-1:NW]`), 1 for R (`wr_data[NW-1:0]`) and 2 for the current code (`wr_data[CPW-1:0]`). Code 3 is ignored.
- R5: With `sync_mode` low, a write reaches its working register on the next edge. `cp_sel` shows a new current code one cycle after the strobe. N, A and R take effect at their counter's next wrap.
- R6: With `sync_mode` high, R and current-code writes alone change neither the reference period nor `cp_sel`.
- R7: With `sync_mode` high, a main-word write causes R, A and N to be loaded together at the next event where the main count is two. Every feedback period is then either entirely the old P·N + A or entirely the new one.
- R8: In staged mode, the held current code reaches `cp_sel` at the next count-of-two event after the counter transfer. It is therefore valid at the first new-value `fb_pulse` and not at the pulse before it.
- R9: While `cnt_off` is high, neither pulse output asserts. After it falls, the counters run at once from the programmed N, A and R.
- R10: After reset, `fb_pulse`, `ref_pulse` and `mod_hi` are low and `cp_sel` equals its reset parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (prescaler-domain rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| psc_tick | input | 1 | One-cycle marker for each completed prescaler division |
| ref_tick | input | 1 | One-cycle marker for each reference event |
| sync_mode | input | 1 | 1 = staged loading, 0 = immediate loading |
| cnt_off | input | 1 | Counter-off standby, counters track working registers |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target of the write (see R4) |
| wr_data | input | NW+AW | Write word |
| mod_hi | output | 1 | 1 selects the P+1 prescaler modulus |
| fb_pulse | output | 1 | Feedback pulse, once per P·N+A input cycles |
| ref_pulse | output | 1 | Reference pulse, once per R reference events |
| cp_sel | output | CPW | Active charge-pump current code |

## Verification
The assertions assume the following about the inputs:
- `psc_tick` and `ref_tick` are single-cycle markers.
- Every programmed N and R is at least 3, so that two pulses can never fall in adjacent cycles.
- `sync_mode` changes only between bursts of writes.

The bench keeps to these limits. Its behavioural prescaler spaces ticks 8 or 9 cycles apart, and its reference ticks come every third cycle. It sweeps only legal N, A ≤ N and R values, and it switches mode only after the dividers have settled on the values just written.

// File: rtl/swdiv_pkg.sv
// Shared definitions for the pulse-swallow divider.
package swdiv_pkg;
    // Target of a parallel write; code values are part of the interface.
    typedef enum logic [1:0] {
        SEL_AN  = 2'd0,
        SEL_R   = 2'd1,
        SEL_CP  = 2'd2,
        SEL_RSV = 2'd3
    } wsel_e;
endpackage

// File: rtl/swdiv_regs.sv
// Holding (shadow) and working (data) registers for N, A, R and the
// current code. Immediate mode writes working registers directly; staged
// mode writes holding registers and transfers them at commit points
// supplied by the main counter. Assumes CPW <= NW.
module swdiv_regs #(
    parameter int NW      = 14,
    parameter int AW      = 6,
    parameter int CPW     = 2,
    parameter int N_INIT  = 3,
    parameter int A_INIT  = 0,
    parameter int R_INIT  = 3,
    parameter int CP_INIT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_mode,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [NW+AW-1:0]     wr_data,
    input  logic                 commit_pt,
    output logic [NW-1:0]        n_dat,
    output logic [AW-1:0]        a_dat,
    output logic [NW-1:0]        r_dat,
    output logic [CPW-1:0]       cp_dat
);
    import swdiv_pkg::*;

    localparam int DW = NW + AW;

    wsel_e          sel;
    logic           wr_an, wr_r, wr_cp;
    logic [NW-1:0]  f_n;
    logic [AW-1:0]  f_a;
    logic [CPW-1:0] f_cp;
    logic [NW-1:0]  sh_n, sh_r;
    logic [AW-1:0]  sh_a;
    logic [CPW-1:0] sh_cp;
    logic           cnt_arm, cp_arm;
    logic           take_cnt, take_cp;

    assign sel   = wsel_e'(wr_sel);
    assign wr_an = wr_en && (sel == SEL_AN);
    assign wr_r  = wr_en && (sel == SEL_R);
    assign wr_cp = wr_en && (sel == SEL_CP);
    assign f_n   = wr_data[NW-1:0];
    assign f_a   = wr_data[DW-1:NW];
    assign f_cp  = wr_data[CPW-1:0];

    assign take_cnt = sync_mode && commit_pt && cnt_arm;
    assign take_cp  = sync_mode && commit_pt && cp_arm;

    // Holding registers capture every write, in either mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_n  <= NW'(N_INIT);
            sh_a  <= AW'(A_INIT);
            sh_r  <= NW'(R_INIT);
            sh_cp <= CPW'(CP_INIT);
        end else begin
            if (wr_an) begin
                sh_n <= f_n;
                sh_a <= f_a;
            end
            if (wr_r)  sh_r  <= f_r_sel(f_n);
            if (wr_cp) sh_cp <= f_cp;
        end
    end

    // Identity helper keeping the R field extraction explicit.
    function automatic logic [NW-1:0] f_r_sel(input logic [NW-1:0] v);
        return v;
    endfunction

    // Arm flags: a main-word write arms the counter transfer; the transfer
    // arms the current-code transfer one division later.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_mode) begin
            cnt_arm <= 1'b0;
            cp_arm  <= 1'b0;
        end else begin
            if (wr_an)         cnt_arm <= 1'b1;
            else if (take_cnt) cnt_arm <= 1'b0;
            if (take_cnt)      cp_arm  <= 1'b1;
            else if (take_cp)  cp_arm  <= 1'b0;
        end
    end

    // Counter working registers: direct write or grouped transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_dat <= NW'(N_INIT);
            a_dat <= AW'(A_INIT);
            r_dat <= NW'(R_INIT);
        end else if (!sync_mode) begin
            if (wr_an) begin
                n_dat <= f_n;
                a_dat <= f_a;
            end
            if (wr_r) r_dat <= f_n;
        end else if (take_cnt) begin
            n_dat <= sh_n;
            a_dat <= sh_a;
            r_dat <= sh_r;
        end
    end

    // Current-code working register: direct write or delayed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cp_dat <= CPW'(CP_INIT);
        else if (!sync_mode && wr_cp)    cp_dat <= f_cp;
        else if (take_cp)                cp_dat <= sh_cp;
    end
endmodule

// File: rtl/swdiv_core.sv
// Main (N) and swallow (A) counters. Counts prescaler events; reloads both
// counters from the working registers when the main count wraps; flags the
// count-of-two event used for staged transfers. Assumes N >= 3, A <= N.
module swdiv_core #(
    parameter int NW     = 14,
    parameter int AW     = 6,
    parameter int N_INIT = 3,
    parameter int A_INIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_off,
    input  logic          psc_tick,
    input  logic [NW-1:0] n_dat,
    input  logic [AW-1:0] a_dat,
    output logic          mod_hi,
    output logic          fb_pulse,
    output logic          commit_pt
);
    logic [NW-1:0] n_cnt;
    logic [AW-1:0] a_cnt;
    logic          run_tick, n_wrap;

    assign run_tick  = psc_tick && !cnt_off;
    assign n_wrap    = (n_cnt <= NW'(1));
    assign commit_pt = run_tick && (n_cnt == NW'(2));
    assign mod_hi    = (a_cnt != '0);

    // Counter update: track data in standby, else count and reload at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cnt <= NW'(N_INIT);
            a_cnt <= AW'(A_INIT);
        end else if (cnt_off) begin
            n_cnt <= n_dat;
            a_cnt <= a_dat;
        end else if (psc_tick) begin
            if (n_wrap) begin
                n_cnt <= n_dat;
                a_cnt <= a_dat;
            end else begin
                n_cnt <= n_cnt - NW'(1);
                if (a_cnt != '0) a_cnt <= a_cnt - AW'(1);
            end
        end
    end

    // One-cycle feedback pulse after the wrapping event.
    always_ff @(posedge clk) begin
        if (!rst_n) fb_pulse <= 1'b0;
        else        fb_pulse <= run_tick && n_wrap;
    end
endmodule

// File: rtl/swdiv_refdiv.sv
// Reference (R) counter. Counts qualified reference events and reloads
// from its working register at wrap. Assumes R >= 3.
module swdiv_refdiv #(
    parameter int NW     = 14,
    parameter int R_INIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_off,
    input  logic          ref_tick,
    input  logic [NW-1:0] r_dat,
    output logic          ref_pulse
);
    logic [NW-1:0] r_cnt;
    logic          r_wrap;

    assign r_wrap = (r_cnt <= NW'(1));

    // Counter update: track data in standby, else count and reload at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)              r_cnt <= NW'(R_INIT);
        else if (cnt_off)        r_cnt <= r_dat;
        else if (ref_tick)       r_cnt <= r_wrap ? r_dat : r_cnt - NW'(1);
    end

    // One-cycle reference pulse after the wrapping event.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_pulse <= 1'b0;
        else        ref_pulse <= ref_tick && !cnt_off && r_wrap;
    end
endmodule

// File: rtl/swallow_div.sv
// Top of the pulse-swallow feedback divider: register bank, main/swallow
// counters and reference counter. All inputs are synchronous to clk.
module swallow_div #(
    parameter int NW      = 14,
    parameter int AW      = 6,
    parameter int CPW     = 2,
    parameter int N_INIT  = 3,
    parameter int A_INIT  = 0,
    parameter int R_INIT  = 3,
    parameter int CP_INIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psc_tick,
    input  logic              ref_tick,
    input  logic              sync_mode,
    input  logic              cnt_off,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [NW+AW-1:0]  wr_data,
    output logic              mod_hi,
    output logic              fb_pulse,
    output logic              ref_pulse,
    output logic [CPW-1:0]    cp_sel
);
    logic [NW-1:0] n_dat, r_dat;
    logic [AW-1:0] a_dat;
    logic          commit_pt;

    swdiv_regs #(
        .NW(NW), .AW(AW), .CPW(CPW), .N_INIT(N_INIT), .A_INIT(A_INIT),
        .R_INIT(R_INIT), .CP_INIT(CP_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .commit_pt(commit_pt),
        .n_dat(n_dat), .a_dat(a_dat), .r_dat(r_dat), .cp_dat(cp_sel)
    );

    swdiv_core #(
        .NW(NW), .AW(AW), .N_INIT(N_INIT), .A_INIT(A_INIT)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_off(cnt_off), .psc_tick(psc_tick),
        .n_dat(n_dat), .a_dat(a_dat), .mod_hi(mod_hi),
        .fb_pulse(fb_pulse), .commit_pt(commit_pt)
    );

    swdiv_refdiv #(
        .NW(NW), .R_INIT(R_INIT)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .cnt_off(cnt_off), .ref_tick(ref_tick),
        .r_dat(r_dat), .ref_pulse(ref_pulse)
    );
endmodule

// File: rtl/swallow_div_chk.sv
// Port-level temporal checks for swallow_div, attached with bind.
module swallow_div_chk #(
    parameter int CPW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           psc_tick,
    input logic           ref_tick,
    input logic           sync_mode,
    input logic           cnt_off,
    input logic           wr_en,
    input logic           mod_hi,
    input logic           fb_pulse,
    input logic           ref_pulse,
    input logic [CPW-1:0] cp_sel
);
    AST_FB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> $past(psc_tick));                                      // R2
    AST_FB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);                                            // R2
    AST_REF_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> $past(ref_tick));                                     // R3
    AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);                                          // R3
    AST_MOD_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mod_hi) && !$past(cnt_off)) |-> $past(psc_tick));            // R1
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_off && $past(cnt_off)) |-> (!fb_pulse && !ref_pulse));         // R9
    AST_CP_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sync_mode) && !$stable(cp_sel)) |-> $past(wr_en));          // R5
    AST_CP_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_mode) && !$stable(cp_sel)) |-> $past(psc_tick));        // R8
endmodule

bind swallow_div swallow_div_chk #(.CPW(CPW)) u_chk (
    .clk(clk), .rst_n(rst_n), .psc_tick(psc_tick), .ref_tick(ref_tick),
    .sync_mode(sync_mode), .cnt_off(cnt_off), .wr_en(wr_en),
    .mod_hi(mod_hi), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
    .cp_sel(cp_sel)
);

// File: tb/tb_swallow_div.sv
// Bench: behavioural dual-modulus prescaler and reference source, sweeps
// of N/A and R, staged-transfer ordering and standby restart.
module tb_swallow_div;
    localparam int NW = 14, AW = 4, CPW = 2, P = 8, RT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psc_tick = 1'b0, ref_tick = 1'b0;
    logic sync_mode = 1'b0, cnt_off = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [NW+AW-1:0] wr_data = '0;
    logic mod_hi, fb_pulse, ref_pulse;
    logic [CPW-1:0] cp_sel;

    int nchk = 0, nerr = 0;
    int cyc = 0, pc = 0, plen = 0, rc = 0;
    int fb_last = 0, fb_per = 0, fb_cnt = 0, fb_cp = 0;
    int rf_last = 0, rf_per = 0, rf_cnt = 0;

    swallow_div #(.NW(NW), .AW(AW), .CPW(CPW)) dut (
        .clk(clk), .rst_n(rst_n), .psc_tick(psc_tick), .ref_tick(ref_tick),
        .sync_mode(sync_mode), .cnt_off(cnt_off), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .mod_hi(mod_hi),
        .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .cp_sel(cp_sel)
    );

    always #10 clk = ~clk;

    // Monitor outputs, then model prescaler and reference source.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (fb_pulse) begin
            fb_per = cyc - fb_last; fb_last = cyc; fb_cnt = fb_cnt + 1;
            fb_cp = int'(cp_sel);
        end
        if (ref_pulse) begin
            rf_per = cyc - rf_last; rf_last = cyc; rf_cnt = rf_cnt + 1;
        end
        if (!rst_n || cnt_off) begin
            psc_tick = 1'b0; pc = 0; plen = 0;
        end else begin
            if (psc_tick || plen == 0) begin
                plen = mod_hi ? P + 1 : P; pc = 1;
            end else pc = pc + 1;
            psc_tick = (pc == plen);
        end
        if (!rst_n) begin ref_tick = 1'b0; rc = 0; end
        else begin rc = (rc + 1) % RT; ref_tick = (rc == 0); end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = (NW+AW)'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_an(input int n, input int a);
        wr(0, (a << NW) | n);
    endtask

    task automatic wait_fb();
        int c0 = fb_cnt;
        while (fb_cnt == c0) @(posedge clk);
    endtask

    task automatic wait_rf();
        int c0 = rf_cnt;
        while (rf_cnt == c0) @(posedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        report();
        $finish;
    end

    initial begin
        int a, m, c0, rel, d, prev_cp, seen_new;
        repeat (4) @(negedge clk);
        chk("R10 fb_pulse", int'(fb_pulse), 0);
        chk("R10 ref_pulse", int'(ref_pulse), 0);
        chk("R10 mod_hi", int'(mod_hi), 0);
        chk("R10 cp_sel", int'(cp_sel), 0);
        rst_n = 1'b1;
        wait_fb(); wait_fb(); wait_fb();
        chk("R1 default period", fb_per, P * 3);

        // R1 R2 R5: immediate-mode sweep over N and A.
        for (int n = 3; n <= 12; n++) begin
            for (int k = 0; k < 4; k++) begin
                a = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? n / 2 : n;
                wr_an(n, a);
                wait_fb(); wait_fb();
                wait_fb(); chk("R1 period", fb_per, P * n + a);
                wait_fb(); chk("R5 period repeat", fb_per, P * n + a);
            end
        end

        // R5: current code updates one cycle after the strobe.
        wr(2, 2);
        chk("R5 cp immediate", int'(cp_sel), 2);
        wr(3, 3);
        chk("R4 reserved code ignored", int'(cp_sel), 2);

        // R3: reference sweep.
        for (int k = 0; k < 4; k++) begin
            int r = (k == 0) ? 3 : (k == 1) ? 4 : (k == 2) ? 7 : 10;
            wr(1, r);
            wait_rf(); wait_rf();
            wait_rf(); chk("R3 ref period", rf_per, RT * r);
            wait_rf(); chk("R3 ref repeat", rf_per, RT * r);
        end

        // R6 R7 R8: staged transfer.
        wr_an(10, 3); wr(2, 1); wr(1, 4);
        wait_fb(); wait_fb(); wait_rf(); wait_rf();
        sync_mode = 1'b1;
        wr(1, 6); wr(2, 3);
        wait_fb(); wait_fb(); wait_fb();
        chk("R6 cp held", int'(cp_sel), 1);
        wait_rf(); wait_rf();
        chk("R6 ref period held", rf_per, RT * 4);
        chk("R6 fb period held", fb_per, P * 10 + 3);
        wr_an(6, 5);
        prev_cp = int'(cp_sel); seen_new = 0;
        for (int i = 0; i < 6; i++) begin
            wait_fb();
            m = (fb_per == P * 6 + 5) ? 1 : 0;
            if (fb_per != P * 10 + 3) chk("R7 no mixed period", fb_per, P * 6 + 5);
            else chk("R7 no mixed period", fb_per, P * 10 + 3);
            if (m == 1 && seen_new == 0) begin
                seen_new = 1;
                chk("R8 cp at first new period", fb_cp, 3);
                chk("R8 cp before new period", prev_cp, 1);
            end
            prev_cp = fb_cp;
        end
        chk("R7 transfer happened", seen_new, 1);
        wait_rf(); wait_rf();
        chk("R7 ref loaded with group", rf_per, RT * 6);
        sync_mode = 1'b0;

        // R9: counter-off standby and restart.
        wr_an(20, 5);
        wait_fb(); wait_fb();
        @(negedge clk); cnt_off = 1'b1;
        repeat (2) @(negedge clk);
        c0 = fb_cnt + rf_cnt;
        wr_an(4, 2);
        repeat (300) @(negedge clk);
        chk("R9 quiet in standby", fb_cnt + rf_cnt - c0, 0);
        cnt_off = 1'b0; rel = cyc;
        wait_fb();
        d = fb_last - rel;
        chk("R9 immediate restart", (d >= P * 4 + 2 - 2 && d <= P * 4 + 2 + 3) ? 1 : 0, 1);
        wait_fb();
        chk("R9 period after restart", fb_per, P * 4 + 2);

        report();
        $finish;
    end
endmodule